// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the low-order word offset for a short, fixed-length memory burst. When a new access starts, the controller pulses a load input together with the starting offset. From then on, each cycle in which an advance input is high steps the burst by one beat. Any cycle without advance suspends the burst, and the offset holds. The offset follows one of two beat orders. In the linear order the offset counts up from the start and wraps inside the group. In the interleaved order the offset is the start XORed with the beat number.

The order is chosen by a quasi-static mode input. That input is registered, so a change shows up on the offset one clock after the edge that samples it. Internally the block keeps the start offset and a beat index. It maps the pair to the output in whichever order is active, so a mode change in the middle of a burst keeps the beat position. A last-beat flag marks the final beat of the group. Advancing past that beat wraps back to the first beat of the same group.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low, and after it is released with no load, the offset is 0 and the last-beat flag is 0.
- R2: In the cycle after a clock edge that samples load high, the offset equals the sampled start value in either mode, and the last-beat flag is 0.
- R3: With mode 0 (linear), each advance raises the offset by one modulo 4, so from start S the beats are S, S+1, S+2, S+3 (mod 4).
- R4: With mode 1 (interleaved), beat k of a burst from start S has offset S XOR k, so start 1 gives 1,0,3,2.
- R5: When load and advance are both high at an edge, load wins: the offset becomes the new start and the beat index restarts at 0.
- R6: An edge with load and advance both low leaves the offset and the last-beat flag unchanged, as long as mode has been stable.
- R7: Advancing from the fourth beat wraps the burst back to its start offset, and the last-beat flag clears.
- R8: The last-beat flag is 1 exactly when three advances have been taken since the last load (beat index 3), and 0 on the other beats.
- R9: A mode change does not affect the offset before the next clock edge. After that edge the offset is the current beat mapped in the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Begin a burst from start_i |
| start_i | input | OFF_W | Starting low-order offset |
| adv_i | input | 1 | Step the burst by one beat |
| mode_i | input | 1 | Beat order: 0 linear, 1 interleaved |
| offset_o | output | OFF_W | Current low-order offset |
| last_o | output | 1 | High on the final beat of the group |

## Verification
The bench builds the block with its default OFF_W of 2, which gives a four-beat group. That size makes the whole space small enough to cover completely. Every start offset is walked through a full burst in both orders, including the wrap back to the start. The small group also places the last-beat boundary, load-over-advance priority, suspend and mid-burst order changes only a few cycles from any load.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst offset sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package burst_seq_pkg;

    // Beat ordering selected by the mode input.
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/burst_index_ctr.sv
// Module: burst_index_ctr
// Holds the burst start offset and the beat index since the last load.
// Load captures the start and clears the index; advance steps the index,
// wrapping naturally at 2**W. Load has priority over advance.
// Assumes: synchronous active-low reset.
module burst_index_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         adv_i,
    input  logic [W-1:0] start_i,
    output logic [W-1:0] start_o,
    output logic [W-1:0] idx_o
);

    localparam logic [W-1:0] IDX_STEP = W'(1);

    logic [W-1:0] start_q;
    logic [W-1:0] idx_q;

    // Capture start offset on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (load_i) begin
            start_q <= start_i;
        end
    end

    // Restart the beat index on load, step it on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load_i) begin
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= idx_q + IDX_STEP;
        end
    end

    assign start_o = start_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/burst_mode_reg.sv
// Module: burst_mode_reg
// Registers the quasi-static mode input, which gives order changes
// one cycle of latency.
// Assumes: mode changes rarely; reset selects the linear order.
module burst_mode_reg
    import burst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_i,
    output order_e order_o
);

    order_e order_q;

    // Sample mode every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= ORDER_LINEAR;
        end else begin
            order_q <= order_e'(mode_i);
        end
    end

    assign order_o = order_q;

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps (start, beat index) to the output offset in the selected order.
// Linear: start + index mod 2**W. Interleaved: start XOR index, built bit
// by bit. Purely combinational.
// Assumes: inputs come from registers.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] idx_i,
    input  order_e       order_i,
    output logic [W-1:0] offset_o
);

    logic [W-1:0] lin_off;
    logic [W-1:0] xor_off;

    // Linear order: modular add of the beat index.
    always_comb begin
        lin_off = start_i + idx_i;
    end

    // Interleaved order: one XOR per offset bit.
    for (genvar b = 0; b < W; b++) begin : g_xor_bit
        assign xor_off[b] = start_i[b] ^ idx_i[b];
    end

    // Select the active order.
    always_comb begin
        offset_o = (order_i == ORDER_XOR) ? xor_off : lin_off;
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst offset sequencer. It loads a start offset, steps on advance,
// holds on suspend and wraps within a 2**OFF_W beat group. The order is
// linear or interleaved, picked by a registered mode input. It also
// flags the last beat of the group.
// Assumes: synchronous active-low reset; mode is quasi-static.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OFF_W-1:0] start_i,
    input  logic             adv_i,
    input  logic             mode_i,
    output logic [OFF_W-1:0] offset_o,
    output logic             last_o
);

    logic [OFF_W-1:0] start_w;
    logic [OFF_W-1:0] idx_w;
    order_e           order_w;

    burst_index_ctr #(.W(OFF_W)) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .start_i (start_i),
        .start_o (start_w),
        .idx_o   (idx_w)
    );

    burst_mode_reg i_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .order_o (order_w)
    );

    burst_order_map #(.W(OFF_W)) i_map (
        .start_i  (start_w),
        .idx_i    (idx_w),
        .order_i  (order_w),
        .offset_o (offset_o)
    );

    // Final beat of the group: every index bit set.
    always_comb begin
        last_o = &idx_w;
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Port-level temporal checks on burst_addr_seq, attached by bind.
// Assumes: inputs are driven from time zero.
module burst_addr_seq_chk #(
    parameter int OFF_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [OFF_W-1:0] start_i,
    input logic             adv_i,
    input logic             mode_i,
    input logic [OFF_W-1:0] offset_o,
    input logic             last_o
);

    localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (offset_o == $past(start_i)));                          // R2

    AST_LOAD_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !last_o);                                               // R8

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && !mode_i && !$past(mode_i))
        |=> ((offset_o - $past(offset_o)) == ONE));                        // R3

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i && (mode_i == $past(mode_i)))
        |=> ($stable(offset_o) && $stable(last_o)));                       // R6

    AST_WRAP_CLEARS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i && !load_i) |=> !last_o);                         // R7

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.OFF_W(OFF_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .start_i  (start_i),
    .adv_i    (adv_i),
    .mode_i   (mode_i),
    .offset_o (offset_o),
    .last_o   (last_o)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int OFF_W      = 2;
    localparam int BEATS      = 1 << OFF_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_i = 1'b0;
    logic [OFF_W-1:0] start_i = '0;
    logic             adv_i = 1'b0;
    logic             mode_i = 1'b0;
    logic [OFF_W-1:0] offset_o;
    logic             last_o;

    int n_checks = 0;
    int n_fails  = 0;

    burst_addr_seq #(.OFF_W(OFF_W)) i_burst_addr_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .start_i  (start_i),
        .adv_i    (adv_i),
        .mode_i   (mode_i),
        .offset_o (offset_o),
        .last_o   (last_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply inputs, pass one rising edge, settle 1 time unit after it.
    task automatic step(input logic ld, input int st, input logic adv, input logic md);
        load_i  = ld;
        start_i = OFF_W'(st);
        adv_i   = adv;
        mode_i  = md;
        @(posedge clk);
        #1;
    endtask

    function automatic int expect_off(input logic md, input int s, input int k);
        return md ? ((s ^ k) % BEATS) : ((s + k) % BEATS);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R1 offset in reset", offset_o, 0);
        check("R1 last in reset", last_o, 0);
        rst_n = 1'b1;
        step(1'b0, 0, 1'b0, 1'b0);
        check("R1 offset after release", offset_o, 0);
        check("R1 last after release", last_o, 0);
    endtask

    // Full burst from every start in one order, plus the wrap.
    task automatic t_full_bursts(input logic md);
        string rq;
        rq = md ? "R4" : "R3";
        step(1'b0, 0, 1'b0, md);
        for (int s = 0; s < BEATS; s++) begin
            step(1'b1, s, 1'b0, md);
            check("R2 load start", offset_o, s);
            check("R8 last after load", last_o, 0);
            for (int k = 1; k < BEATS; k++) begin
                step(1'b0, 0, 1'b1, md);
                check(rq, offset_o, expect_off(md, s, k));
                check("R8 last flag", last_o, (k == BEATS - 1) ? 1 : 0);
            end
            step(1'b0, 0, 1'b1, md);
            check("R7 wrap to start", offset_o, s);
            check("R7 last cleared", last_o, 0);
        end
    endtask

    task automatic t_suspend();
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b1, 1, 1'b0, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 3, 1'b0, 1'b0);
            check("R6 suspend offset", offset_o, 2);
            check("R6 suspend last", last_o, 0);
        end
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R6 hold on last beat", offset_o, 0);
        check("R6 last held", last_o, 1);
    endtask

    task automatic t_load_priority();
        step(1'b1, 0, 1'b0, 1'b1);
        step(1'b0, 0, 1'b1, 1'b1);
        step(1'b0, 0, 1'b1, 1'b1);
        step(1'b1, 2, 1'b1, 1'b1);
        check("R5 load beats advance", offset_o, 2);
        check("R5 last after load", last_o, 0);
        step(1'b0, 0, 1'b1, 1'b1);
        check("R5 index restarted", offset_o, 3);
    endtask

    task automatic t_mode_latency();
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b1, 1, 1'b0, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0);
        check("R9 linear beat 1", offset_o, 2);
        mode_i = 1'b1;
        #2;
        check("R9 no change before edge", offset_o, 2);
        step(1'b0, 0, 1'b0, 1'b1);
        check("R9 interleaved after edge", offset_o, 0);
        step(1'b0, 0, 1'b1, 1'b1);
        check("R9 interleaved beat 2", offset_o, 3);
        mode_i = 1'b0;
        #2;
        check("R9 still interleaved", offset_o, 3);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R9 back to linear", offset_o, 3);
        step(1'b0, 0, 1'b1, 1'b0);
        check("R9 linear beat 3", offset_o, 0);
        check("R8 last on beat 3", last_o, 1);
    endtask

    initial begin
        t_reset();
        t_full_bursts(1'b0);
        t_full_bursts(1'b1);
        t_suspend();
        t_load_priority();
        t_mode_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule